// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a reference clock into a single-cycle enable pulse at sixteen times the serial bit rate. It is what the transmit and receive engines of a UART use to pace their oversampling. The rate is set by a 16-bit whole-cycle divisor and a 6-bit fraction in steps of 1/64. The divisor is the reference frequency over sixteen times the bit rate.

The whole part sets the base spacing between pulses. A 6-bit accumulator gains the fraction on every pulse, and each time it wraps, the next spacing grows by one cycle. Over 64 pulses this spreads the fractional part evenly.

The block keeps an active copy of the divisor. A changed divisor is taken into that copy only while no character is in flight, so a frame never changes rate half way through. Taking in a new divisor restarts the spacing counter and clears the accumulator. A divisor that cannot give a valid rate raises a flag and stops all pulses.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is held, tick_o is 0 and div_bad_o is 1: the active divisor resets to whole part 0 and fraction 0.
- R2: With fraction 0 and whole part N ≥ 1, pulses come every N cycles, and each pulse is one cycle wide unless N = 1.
- R3: An active whole part of 0 sets div_bad_o to 1, and no pulse appears for as long as it stays active.
- R4: A whole part of 0xFFFF with a non-zero fraction is invalid (div_bad_o = 1, no pulses). 0xFFFF with fraction 0 is valid (div_bad_o = 0).
- R5: While char_busy_i is 1, changes on div_int_i and div_frac_i have no effect on pulse spacing or on div_bad_o. A pending change is taken in at the first clock edge at which char_busy_i is 0.
- R6: With whole part N and fraction F, the spacing between pulse j and pulse j+1 (j ≥ 1) is N + c. Here c is 1 when ((j·F) mod 64) + F ≥ 64, and 0 otherwise.
- R7: Taking in a new divisor clears the counter and the accumulator. If the inputs are presented in cycle 0 with char_busy_i low, the first pulse comes in cycle N+1 and none comes in cycles 1 to N.
- R8: While enable_i is 0, no pulse is made and the counter and accumulator are held clear. If enable_i rises in cycle 0, the first pulse comes in cycle N.
- R9: div_bad_o shows the validity of a newly taken divisor one cycle after the inputs are presented with char_busy_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| enable_i | input | 1 | Allows pulse generation |
| char_busy_i | input | 1 | A character is being sent or received |
| div_int_i | input | 16 | Requested whole-cycle divisor |
| div_frac_i | input | 6 | Requested fraction, in 1/64 steps |
| tick_o | output | 1 | Single-cycle 16x oversampling pulse |
| div_bad_o | output | 1 | Active divisor is invalid |

## Verification
Inputs are driven on the falling edge, and that falling edge is counted as cycle 0.
- div_bad_o is due one falling edge after a divisor is taken in.
- After a divisor is taken in, the first pulse is due at falling edge N+1.
- After enable_i rises, the first pulse is due at falling edge N.
- Every later spacing is due N or N+1 falling edges after the previous pulse, as R6 gives.

The bench walks the clock one falling edge at a time. At each falling edge up to the due one, it checks that no early pulse is present, and then it checks that the pulse is there. Spacings are counted from pulse to pulse against the accumulator model, so a pulse that comes one cycle late or early fails the check.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int DEF_INT_W  = 16;
    localparam int DEF_FRAC_W = 6;

    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,
        GEN_RUN  = 2'd1,
        GEN_BAD  = 2'd2
    } gen_mode_e;

    // A divisor is usable unless its whole part is zero, or the whole part
    // is at its maximum and a fraction would push it past the range.
    function automatic logic div_legal(input logic [31:0] whole,
                                       input logic [31:0] frac,
                                       input int          whole_w);
        logic [31:0] whole_max;
        whole_max = (32'd1 << whole_w) - 32'd1;
        return !((whole == 32'd0) || ((whole == whole_max) && (frac != 32'd0)));
    endfunction

endpackage

// File: rtl/bgen_div_shadow.sv
module bgen_div_shadow #(
    parameter int INT_W  = baud_pkg::DEF_INT_W,
    parameter int FRAC_W = baud_pkg::DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_i,
    input  logic [INT_W-1:0]  int_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [INT_W-1:0]  int_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic              reload_o,
    output logic              bad_o
);
    logic [INT_W-1:0]  int_q;
    logic [FRAC_W-1:0] frac_q;
    logic              differs;

    assign differs  = (int_i != int_q) || (frac_i != frac_q);
    assign reload_o = differs && !busy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            int_q  <= '0;
            frac_q <= '0;
        end else if (reload_o) begin
            int_q  <= int_i;
            frac_q <= frac_i;
        end
    end

    assign int_o  = int_q;
    assign frac_o = frac_q;
    assign bad_o  = !baud_pkg::div_legal(32'(int_q), 32'(frac_q), INT_W);

    // R5: the active divisor never moves while a character is in flight
    assert_hold_busy_R5: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> ($stable(int_q) && $stable(frac_q)));

endmodule

// File: rtl/bgen_frac_acc.sv
module bgen_frac_acc #(
    parameter int FRAC_W = baud_pkg::DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              adv_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              carry_o
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    assign sum     = {1'b0, acc_q} + {1'b0, frac_i};
    assign carry_o = sum[FRAC_W];

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            acc_q <= '0;
        end else if (adv_i) begin
            acc_q <= sum[FRAC_W-1:0];
        end
    end

    // R6: the fraction accumulates only on a pulse
    assert_acc_only_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && !clr_i) |=> $stable(acc_q));

    // R7: taking in a divisor empties the accumulator
    assert_acc_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (acc_q == '0));

endmodule

// File: rtl/bgen_tick_cnt.sv
module bgen_tick_cnt #(
    parameter int INT_W = baud_pkg::DEF_INT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [INT_W-1:0] int_i,
    input  logic             stretch_i,
    output logic             hit_o
);
    localparam int TW = INT_W + 1;

    logic [INT_W-1:0] cnt_q;
    logic [TW-1:0]    last;

    // Last count of this period: whole part minus one, plus a stretch cycle.
    assign last  = {1'b0, int_i} - TW'(1) + TW'(stretch_i);
    assign hit_o = run_i && ({1'b0, cnt_q} == last);

    always_ff @(posedge clk) begin
        if (rst || !run_i || hit_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + INT_W'(1);
        end
    end

    // R6: the count never passes the end of the current period
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        run_i |-> ({1'b0, cnt_q} <= last));

    // R8: a stopped generator restarts from zero
    assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int INT_W  = baud_pkg::DEF_INT_W,
    parameter int FRAC_W = baud_pkg::DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              char_busy_i,
    input  logic [INT_W-1:0]  div_int_i,
    input  logic [FRAC_W-1:0] div_frac_i,
    output logic              tick_o,
    output logic              div_bad_o
);
    import baud_pkg::*;

    logic [INT_W-1:0]  act_int;
    logic [FRAC_W-1:0] act_frac;
    logic              reload;
    logic              bad;
    logic              carry;
    logic              hit;
    logic              run;
    logic              tick_q;
    gen_mode_e         mode;

    bgen_div_shadow #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .busy_i   (char_busy_i),
        .int_i    (div_int_i),
        .frac_i   (div_frac_i),
        .int_o    (act_int),
        .frac_o   (act_frac),
        .reload_o (reload),
        .bad_o    (bad)
    );

    always_comb begin
        if (bad)            mode = GEN_BAD;
        else if (!enable_i) mode = GEN_IDLE;
        else                mode = GEN_RUN;
    end

    // A divisor being taken in this cycle suppresses counting and any pulse.
    assign run = (mode == GEN_RUN) && !reload;

    bgen_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (!run),
        .adv_i   (hit),
        .frac_i  (act_frac),
        .carry_o (carry)
    );

    bgen_tick_cnt #(.INT_W(INT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .run_i     (run),
        .int_i     (act_int),
        .stretch_i (carry),
        .hit_o     (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= hit;
    end

    assign tick_o    = tick_q;
    assign div_bad_o = bad;

    // R3: no pulse is ever seen alongside an invalid divisor
    assert_no_tick_bad_R3: assert property (@(posedge clk) disable iff (rst)
        !(tick_o && div_bad_o));

    // R8: a pulse follows only a cycle in which generation was enabled
    assert_tick_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> !tick_o);

endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable_i = 1'b0;
    logic        char_busy_i = 1'b0;
    logic [15:0] div_int_i = 16'd0;
    logic [5:0]  div_frac_i = 6'd0;
    logic        tick_o;
    logic        div_bad_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    baud_tick_gen dut_i (
        .clk         (clk),
        .rst         (rst),
        .enable_i    (enable_i),
        .char_busy_i (char_busy_i),
        .div_int_i   (div_int_i),
        .div_frac_i  (div_frac_i),
        .tick_o      (tick_o),
        .div_bad_o   (div_bad_o)
    );

    localparam int NV = 6;
    localparam logic [15:0] V_INT  [NV] = '{16'd1, 16'd3, 16'd3, 16'd1, 16'd7, 16'd2};
    localparam logic [5:0]  V_FRAC [NV] = '{6'd0, 6'd0, 6'd5, 6'd32, 6'd63, 6'd17};
    localparam int          V_CNT  [NV] = '{8, 8, 70, 70, 70, 70};

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic apply(input logic [15:0] w, input logic [5:0] f);
        div_int_i  = w;
        div_frac_i = f;
    endtask

    // Ticks must be absent for cycles 1..n-1 and present in cycle n.
    task automatic expect_tick_at(input int n, input string req);
        int early = 0;
        for (int k = 1; k < n; k++) begin
            step();
            if (tick_o) early++;
        end
        chk(early == 0, req, early, 0);
        step();
        chk(tick_o == 1'b1, req, tick_o, 1);
    endtask

    // Starting on a tick sample, measure m spacings against the model.
    task automatic measure(input int w, input int f, input int m, input string req);
        for (int j = 1; j <= m; j++) begin
            int gap = 0;
            int exp;
            exp = w + ((((j * f) % 64) + f) >= 64 ? 1 : 0);
            do begin
                step();
                gap++;
            end while (!tick_o && gap < 300);
            chk(gap == exp, req, gap, exp);
        end
    endtask

    task automatic no_tick_for(input int n, input string req);
        int seen = 0;
        for (int k = 0; k < n; k++) begin
            step();
            if (tick_o) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        for (int k = 0; k < 4; k++) step();
        chk(tick_o == 1'b0, "R1 tick in reset", tick_o, 0);
        chk(div_bad_o == 1'b1, "R1 bad in reset", div_bad_o, 1);
        rst = 1'b0;
        enable_i = 1'b1;
        // R3: zero divisor after reset stays invalid with no pulses
        no_tick_for(50, "R3 zero after reset");
        chk(div_bad_o == 1'b1, "R3 bad after reset", div_bad_o, 1);

        // Table walk: R2, R6, R7
        for (int v = 0; v < NV; v++) begin
            apply(V_INT[v], V_FRAC[v]);
            expect_tick_at(int'(V_INT[v]) + 1, "R7 first tick after reload");
            chk(div_bad_o == 1'b0, "R9 valid divisor", div_bad_o, 0);
            if (V_FRAC[v] == 6'd0)
                measure(int'(V_INT[v]), 0, V_CNT[v], "R2 spacing");
            else
                measure(int'(V_INT[v]), int'(V_FRAC[v]), V_CNT[v], "R6 fractional spacing");
        end

        // R3 / R9: zero whole part
        apply(16'd0, 6'd0);
        step();
        chk(div_bad_o == 1'b1, "R9 bad one cycle after", div_bad_o, 1);
        chk(tick_o == 1'b0, "R3 no tick at switch", tick_o, 0);
        no_tick_for(100, "R3 zero divisor");

        // R4: maximum whole part
        apply(16'hFFFF, 6'd1);
        step();
        chk(div_bad_o == 1'b1, "R4 max with fraction", div_bad_o, 1);
        no_tick_for(100, "R4 max with fraction");
        apply(16'hFFFF, 6'd0);
        step();
        chk(div_bad_o == 1'b0, "R4 max without fraction", div_bad_o, 0);

        // R5: changes held back while a character is busy
        apply(16'd4, 6'd0);
        expect_tick_at(5, "R7 reload to 4");
        char_busy_i = 1'b1;
        apply(16'd0, 6'd0);
        step();
        step();
        chk(div_bad_o == 1'b0, "R5 bad flag held", div_bad_o, 0);
        apply(16'd7, 6'd9);
        do step(); while (!tick_o);
        measure(4, 0, 6, "R5 spacing held");
        char_busy_i = 1'b0;
        expect_tick_at(8, "R5 applied after busy");
        measure(7, 9, 20, "R5 new divisor spacing");

        // R8: enable gating and restart
        apply(16'd7, 6'd0);
        expect_tick_at(8, "R7 reload to 7");
        enable_i = 1'b0;
        no_tick_for(100, "R8 disabled");
        enable_i = 1'b1;
        expect_tick_at(7, "R8 resume");
        measure(7, 0, 5, "R8 spacing after resume");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule